// File: doc/BRIEF.md
# GPIO Port Controller with Per-Pin Interrupt Detection

This block controls one general-purpose I/O port of up to eight pins through a synchronous register port. Each pin owns a 32-byte register window. In that window software sets up the pin: whether it is enabled, which way it drives, its output value, a float control that releases the driver, and an optional debounce filter. Software reads the pin's filtered input level from the same window.

Every pin also has an interrupt detector. It can watch for an active level, a single edge of a chosen polarity, or both edges. Pending bits stay in a per-pin status flag. Software clears a flag by writing to the pin's clear offset. One port-wide status word collects the flags, and a single combined interrupt line goes to the rest of the chip. A free-running millisecond tick input sets the time base for debounce.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0. `pin_oe` and `irq` are 0, so each pin is a disabled input with no trigger.
- R2: Pin i's window starts at byte address 0x20*i. The configuration word at window offset 0x00 reads back as written over bits 6:0. Its fields are: bit0 enable; bit1 output mode; bits 3:2 trigger type (0 none, 1 level, 2 single edge, 3 double edge); bit4 polarity (1 = high/rising, 0 = low/falling); bit5 debounce enable; bit6 interrupt enable.
- R3: `pin_oe[i]` is high exactly when pin i is enabled, in output mode, and its float bit (offset 0x0C, bit0) is 0. `pin_out[i]` follows bit0 of offset 0x10.
- R4: Bit0 of offset 0x08 returns the filtered input. With debounce off, a change on `pin_in[i]` shows there on the third rising clock edge after it is applied.
- R5: When debounce is enabled and the threshold at offset 0x04 (bits 7:0) is non-zero, a new input level is accepted only once it has differed from the accepted level for that many `ms_tick` pulses. A return to the old level restarts the count, so a shorter pulse is ignored. A threshold of 0 disables filtering.
- R6: In level mode the status flag is set while the pin is enabled and its level equals the polarity. A write to offset 0x14 clears the flag for one cycle, and the flag reasserts if the level is still active.
- R7: In single-edge mode a rising edge (polarity 1) or a falling edge (polarity 0) of the filtered level sets the flag. The flag stays set until a write to offset 0x14. An edge that arrives in the same cycle as the clear still sets the flag.
- R8: In double-edge mode both transitions set the flag, whatever the polarity bit says.
- R9: Address 0x104 returns the port status word, with bit i holding pin i's flag. With trigger type none, or with the pin disabled, no flag is ever raised.
- R10: `irq` is the OR, over all pins, of each pin's flag ANDed with its enable and interrupt-enable bits. Clearing interrupt enable hides a pending flag from `irq` but does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| pin_in | input | 8 | Raw pad input levels |
| pin_out | output | 8 | Driven output values |
| pin_oe | output | 8 | Output-driver enables |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its default parameters: eight pins, two synchronizer stages and an 8-bit debounce threshold. With all eight windows present, the top window and the status word at 0x104 sit next to each other, so the decode boundary between them is exercised. The debounce threshold is set to 3 so that both a glitch cut off after two ticks and an acceptance on the third tick fall inside a short run. A behavioural model in the bench tracks every pin and compares outputs and read data on each cycle. The one-cycle dip of a level flag after a clear and the latching of edges are checked against that model.

// File: rtl/gpio_port_pkg.sv
// Shared types and register offsets for the GPIO port controller.
// Assumes each pin window is 32 bytes, so the pin index sits at address bit 5.
package gpio_port_pkg;

    localparam int WIN_SHIFT = 5;

    localparam logic [4:0] OFF_CFG = 5'h00;
    localparam logic [4:0] OFF_DBT = 5'h04;
    localparam logic [4:0] OFF_IN  = 5'h08;
    localparam logic [4:0] OFF_FLT = 5'h0C;
    localparam logic [4:0] OFF_OUT = 5'h10;
    localparam logic [4:0] OFF_CLR = 5'h14;

    localparam int STATUS_ADDR = 'h104;

    typedef enum logic [1:0] {
        TRIG_NONE  = 2'd0,
        TRIG_LEVEL = 2'd1,
        TRIG_EDGE  = 2'd2,
        TRIG_BOTH  = 2'd3
    } trig_e;

    // Field order sets the bit positions: irq_en is bit6, en is bit0.
    typedef struct packed {
        logic  irq_en;
        logic  db_en;
        logic  pol;
        trig_e trig;
        logic  dir_out;
        logic  en;
    } pin_cfg_t;

endpackage

// File: rtl/gpio_pin_filter.sv
// Input conditioning for one pin: a synchronizer chain followed by an
// optional debounce filter that counts millisecond ticks.
// Assumes SYNC_STAGES >= 2 and that ms_tick is a single-cycle pulse.
module gpio_pin_filter #(
    parameter int DB_W        = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pin_raw,
    input  logic            ms_tick,
    input  logic            db_en,
    input  logic [DB_W-1:0] thr,
    output logic            level
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [DB_W-1:0]        cnt_q;
    logic                   lvl_q;
    logic                   sampled;
    logic [DB_W:0]          cnt_inc;
    logic                   bypass;

    assign sampled = sync_q[SYNC_STAGES-1];
    assign cnt_inc = {1'b0, cnt_q} + 1'b1;
    assign bypass  = !db_en || (thr == '0);
    assign level   = lvl_q;

    // Shift the raw pad value through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_raw};
    end

    // Accept a new level directly or after thr ticks of stable disagreement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= 1'b0;
            cnt_q <= '0;
        end else if (bypass) begin
            lvl_q <= sampled;
            cnt_q <= '0;
        end else if (sampled == lvl_q) begin
            cnt_q <= '0;
        end else if (ms_tick) begin
            if (cnt_inc >= {1'b0, thr}) begin
                lvl_q <= sampled;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_inc[DB_W-1:0];
            end
        end
    end

endmodule

// File: rtl/gpio_pin_irq.sv
// Interrupt detector for one pin: level, single-edge or double-edge
// trigger with a polarity bit, and a pending flag that software clears.
// Assumes level is already synchronous to clk.
module gpio_pin_irq
    import gpio_port_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  level,
    input  logic  en,
    input  trig_e trig,
    input  logic  pol,
    input  logic  clr,
    output logic  pend
);

    logic lvl_d;
    logic rise;
    logic fall;
    logic kept;
    logic pend_q;

    assign rise = level && !lvl_d;
    assign fall = !level && lvl_d;
    assign kept = clr ? 1'b0 : pend_q;
    assign pend = pend_q;

    // Remember the previous level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_d <= 1'b0;
        else        lvl_d <= level;
    end

    // Update the pending flag from the selected trigger rule.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else begin
            unique case (trig)
                TRIG_NONE:  pend_q <= 1'b0;
                TRIG_LEVEL: pend_q <= !clr && en && (level == pol);
                TRIG_EDGE:  pend_q <= kept || (en && (pol ? rise : fall));
                TRIG_BOTH:  pend_q <= kept || (en && (rise || fall));
                default:    pend_q <= 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/gpio_port_ctrl.sv
// Register-mapped controller for one GPIO port. Each pin has a 32-byte
// window of configuration, data and clear registers. One status word and
// one combined interrupt output serve the whole port.
// Assumes NUM_PINS <= 8, so the status word at 0x104 lies above every window.
module gpio_port_ctrl
    import gpio_port_pkg::*;
#(
    parameter int NUM_PINS    = 8,
    parameter int ADDR_W      = 12,
    parameter int DATA_W      = 32,
    parameter int DB_W        = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_we,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    input  logic                ms_tick,
    output logic                irq
);

    localparam int WIN_W = ADDR_W - WIN_SHIFT;
    localparam int CFG_W = $bits(pin_cfg_t);

    logic [WIN_W-1:0] win;
    logic [4:0]       off;
    logic             stat_hit;

    pin_cfg_t         cfg_q  [NUM_PINS];
    logic [DB_W-1:0]  thr_q  [NUM_PINS];
    logic [NUM_PINS-1:0] flt_v;
    logic [NUM_PINS-1:0] outv_v;
    logic [NUM_PINS-1:0] lvl_v;
    logic [NUM_PINS-1:0] stat_v;
    logic [NUM_PINS-1:0] clr_v;
    logic [NUM_PINS-1:0] en_v;
    logic [NUM_PINS-1:0] ie_v;
    logic [NUM_PINS-1:0] edge_v;
    logic [NUM_PINS-1:0] none_v;

    assign win      = reg_addr[ADDR_W-1:WIN_SHIFT];
    assign off      = reg_addr[WIN_SHIFT-1:0];
    assign stat_hit = (reg_addr == ADDR_W'(STATUS_ADDR));

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        logic sel;
        assign sel = (win == WIN_W'(i));

        // Per-pin register writes decoded from the window offset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_q[i]  <= '0;
                thr_q[i]  <= '0;
                flt_v[i]  <= 1'b0;
                outv_v[i] <= 1'b0;
            end else if (reg_we && sel) begin
                if (off == OFF_CFG) cfg_q[i]  <= pin_cfg_t'(reg_wdata[CFG_W-1:0]);
                if (off == OFF_DBT) thr_q[i]  <= reg_wdata[DB_W-1:0];
                if (off == OFF_FLT) flt_v[i]  <= reg_wdata[0];
                if (off == OFF_OUT) outv_v[i] <= reg_wdata[0];
            end
        end

        assign clr_v[i]  = reg_we && sel && (off == OFF_CLR);
        assign en_v[i]   = cfg_q[i].en;
        assign ie_v[i]   = cfg_q[i].irq_en;
        assign edge_v[i] = cfg_q[i].trig[1];
        assign none_v[i] = (cfg_q[i].trig == TRIG_NONE);

        assign pin_oe[i]  = cfg_q[i].en && cfg_q[i].dir_out && !flt_v[i];
        assign pin_out[i] = outv_v[i];

        gpio_pin_filter #(
            .DB_W        (DB_W),
            .SYNC_STAGES (SYNC_STAGES)
        ) u_filter (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin_raw (pin_in[i]),
            .ms_tick (ms_tick),
            .db_en   (cfg_q[i].db_en),
            .thr     (thr_q[i]),
            .level   (lvl_v[i])
        );

        gpio_pin_irq u_irq (
            .clk   (clk),
            .rst_n (rst_n),
            .level (lvl_v[i]),
            .en    (cfg_q[i].en),
            .trig  (cfg_q[i].trig),
            .pol   (cfg_q[i].pol),
            .clr   (clr_v[i]),
            .pend  (stat_v[i])
        );
    end

    assign irq = |(stat_v & en_v & ie_v);

    // Read multiplexer: status word or the addressed pin's register.
    always_comb begin
        reg_rdata = '0;
        if (stat_hit) begin
            reg_rdata[NUM_PINS-1:0] = stat_v;
        end else begin
            for (int p = 0; p < NUM_PINS; p++) begin
                if (win == WIN_W'(p)) begin
                    unique case (off)
                        OFF_CFG: reg_rdata[CFG_W-1:0] = cfg_q[p];
                        OFF_DBT: reg_rdata[DB_W-1:0]  = thr_q[p];
                        OFF_IN:  reg_rdata[0]         = lvl_v[p];
                        OFF_FLT: reg_rdata[0]         = flt_v[p];
                        OFF_OUT: reg_rdata[0]         = outv_v[p];
                        default: reg_rdata            = '0;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/gpio_port_chk.sv
// Assertion checker for gpio_port_ctrl, attached with bind below.
// Assumes the internal per-pin vectors named in the bind exist in the top.
module gpio_port_chk #(
    parameter int NUM_PINS = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                irq,
    input logic [NUM_PINS-1:0] pin_oe,
    input logic [NUM_PINS-1:0] en_v,
    input logic [NUM_PINS-1:0] ie_v,
    input logic [NUM_PINS-1:0] flt_v,
    input logic [NUM_PINS-1:0] edge_v,
    input logic [NUM_PINS-1:0] none_v,
    input logic [NUM_PINS-1:0] clr_v,
    input logic [NUM_PINS-1:0] stat_v
);

    // R1: the first cycle out of reset shows no drive and no interrupt.
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (pin_oe == '0 && !irq));

    // R3: a driven pin is enabled and not floated.
    a_r3_oe_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & ~en_v) == '0);
    a_r3_float_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & flt_v) == '0);

    // R10: the interrupt line needs at least one enabled, unmasked pin.
    a_r10_irq_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|(en_v & ie_v)));

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
        // R7: an edge flag holds until a clear write.
        a_r7_edge_latched: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(stat_v[i]) && $past(edge_v[i]) && !$past(clr_v[i])) |-> stat_v[i]);
        // R9: trigger type none raises no flag.
        a_r9_none_silent: assert property (@(posedge clk) disable iff (!rst_n)
            $past(none_v[i]) |-> !stat_v[i]);
    end

endmodule

bind gpio_port_ctrl gpio_port_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .irq    (irq),
    .pin_oe (pin_oe),
    .en_v   (en_v),
    .ie_v   (ie_v),
    .flt_v  (flt_v),
    .edge_v (edge_v),
    .none_v (none_v),
    .clr_v  (clr_v),
    .stat_v (stat_v)
);

// File: tb/gpio_port_ctrl_bench.sv
// Self-checking bench: a behavioural per-pin model compared on every clock,
// plus directed checks with hand-computed values.
module gpio_port_ctrl_bench;

    localparam int NP = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out;
    logic [NP-1:0] pin_oe;
    logic        ms_tick = 1'b0;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit cmp_on = 0;

    always #5 clk = ~clk;

    gpio_port_ctrl u_gpio_port_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .ms_tick   (ms_tick),
        .irq       (irq)
    );

    // Reference model state, one entry per pin.
    int m_cfg[NP], m_thr[NP], m_flt[NP], m_ov[NP];
    int m_s1[NP], m_s2[NP], m_lvl[NP], m_lvd[NP], m_cnt[NP], m_st[NP];

    always @(posedge clk) begin
        for (int p = 0; p < NP; p++) begin
            if (!rst_n) begin
                m_cfg[p] = 0; m_thr[p] = 0; m_flt[p] = 0; m_ov[p] = 0;
                m_s1[p] = 0; m_s2[p] = 0; m_lvl[p] = 0; m_lvd[p] = 0;
                m_cnt[p] = 0; m_st[p] = 0;
            end else begin
                int en, tr, pol, rise, fall, sel, clr, nst;
                en   = m_cfg[p] & 1;
                tr   = (m_cfg[p] >> 2) & 3;
                pol  = (m_cfg[p] >> 4) & 1;
                rise = (m_lvl[p] == 1 && m_lvd[p] == 0) ? 1 : 0;
                fall = (m_lvl[p] == 0 && m_lvd[p] == 1) ? 1 : 0;
                sel  = (reg_addr < 12'h100 && int'(reg_addr >> 5) == p) ? 1 : 0;
                clr  = (reg_we && sel && reg_addr[4:0] == 5'h14) ? 1 : 0;
                case (tr)
                    0: nst = 0;
                    1: nst = (!clr && en && m_lvl[p] == pol) ? 1 : 0;
                    2: nst = ((clr ? 0 : m_st[p]) || (en && (pol ? rise : fall))) ? 1 : 0;
                    default: nst = ((clr ? 0 : m_st[p]) || (en && (rise || fall))) ? 1 : 0;
                endcase
                m_st[p]  = nst;
                m_lvd[p] = m_lvl[p];
                if (((m_cfg[p] >> 5) & 1) == 0 || m_thr[p] == 0) begin
                    m_lvl[p] = m_s2[p]; m_cnt[p] = 0;
                end else if (m_s2[p] == m_lvl[p]) begin
                    m_cnt[p] = 0;
                end else if (ms_tick) begin
                    if (m_cnt[p] + 1 >= m_thr[p]) begin
                        m_lvl[p] = m_s2[p]; m_cnt[p] = 0;
                    end else begin
                        m_cnt[p] = m_cnt[p] + 1;
                    end
                end
                m_s2[p] = m_s1[p];
                m_s1[p] = pin_in[p];
                if (reg_we && sel) begin
                    case (reg_addr[4:0])
                        5'h00: m_cfg[p] = reg_wdata[6:0];
                        5'h04: m_thr[p] = reg_wdata[7:0];
                        5'h0C: m_flt[p] = reg_wdata[0];
                        5'h10: m_ov[p]  = reg_wdata[0];
                        default: ;
                    endcase
                end
            end
        end
    end

    function automatic int exp_rd(input logic [11:0] a);
        int p, v;
        v = 0;
        if (a == 12'h104) begin
            for (int q = 0; q < NP; q++) v = v | (m_st[q] << q);
        end else if (a < 12'h100) begin
            p = a >> 5;
            case (a[4:0])
                5'h00: v = m_cfg[p];
                5'h04: v = m_thr[p];
                5'h08: v = m_lvl[p];
                5'h0C: v = m_flt[p];
                5'h10: v = m_ov[p];
                default: v = 0;
            endcase
        end
        return v;
    endfunction

    function automatic string rd_tag(input logic [11:0] a);
        if (a == 12'h104) return "R9";
        if (a >= 12'h100) return "R1";
        case (a[4:0])
            5'h00: return "R2";
            5'h04: return "R5";
            5'h08: return "R4";
            5'h0C, 5'h10: return "R3";
            default: return "R1";
        endcase
    endfunction

    task automatic chk(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    // Per-cycle comparison against the model, away from the clock edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            int eoe, eout, eirq;
            eoe = 0; eout = 0; eirq = 0;
            for (int p = 0; p < NP; p++) begin
                if ((m_cfg[p] & 3) == 3 && m_flt[p] == 0) eoe = eoe | (1 << p);
                eout = eout | (m_ov[p] << p);
                if (m_st[p] && (m_cfg[p] & 1) && ((m_cfg[p] >> 6) & 1)) eirq = 1;
            end
            chk("R3 pin_oe", int'(pin_oe), eoe);
            chk("R3 pin_out", int'(pin_out), eout);
            chk("R10 irq", int'(irq), eirq);
            chk(rd_tag(reg_addr), int'(reg_rdata), exp_rd(reg_addr));
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(posedge clk); #2;
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #2;
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output int v);
        @(posedge clk); #2;
        reg_we = 1'b0; reg_addr = a;
        #1 v = int'(reg_rdata);
    endtask

    task automatic set_pin(input int p, input logic val);
        @(posedge clk); #2;
        pin_in[p] = val;
    endtask

    task automatic tick_once();
        @(posedge clk); #2 ms_tick = 1'b1;
        @(posedge clk); #2 ms_tick = 1'b0;
        repeat (2) @(posedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin : watchdog
        #2000000;
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        int v;
        idle(4);
        #2 rst_n = 1'b1;
        cmp_on = 1;

        // R1: reset state
        rd(12'h000, v); chk("R1 cfg0", v, 0);
        rd(12'h104, v); chk("R1 status", v, 0);
        #1 chk("R1 pin_oe", int'(pin_oe), 0);
        chk("R1 irq", int'(irq), 0);

        // R2: configuration readback
        wr(12'h060, 32'hFFFF_FF7E);
        rd(12'h060, v); chk("R2 cfg readback", v, 'h7E);
        wr(12'h060, 32'h0);

        // R3: output drive and float
        wr(12'h020, 32'h03);
        wr(12'h030, 32'h01);
        #1 chk("R3 oe driven", int'(pin_oe[1]), 1);
        chk("R3 out value", int'(pin_out[1]), 1);
        wr(12'h02C, 32'h01);
        #1 chk("R3 float releases", int'(pin_oe[1]), 0);

        // R4: input latency without debounce
        rd(12'h008, v);
        set_pin(0, 1'b1);
        rd(12'h008, v); chk("R4 edge1", v, 0);
        rd(12'h008, v); chk("R4 edge2", v, 0);
        rd(12'h008, v); chk("R4 edge3", v, 1);

        // R5: debounce glitch rejected, stable level accepted
        wr(12'h084, 32'h03);
        wr(12'h080, 32'h21);
        set_pin(4, 1'b1); idle(4);
        tick_once(); tick_once();
        set_pin(4, 1'b0); idle(4);
        rd(12'h088, v); chk("R5 glitch ignored", v, 0);
        set_pin(4, 1'b1); idle(4);
        tick_once(); tick_once();
        rd(12'h088, v); chk("R5 two ticks short", v, 0);
        tick_once();
        rd(12'h088, v); chk("R5 third tick accepts", v, 1);

        // R6: level-high trigger and clear with reassertion
        wr(12'h040, 32'h55);
        set_pin(2, 1'b1); idle(6);
        rd(12'h104, v); chk("R6 level set", (v >> 2) & 1, 1);
        #1 chk("R6 irq high", int'(irq), 1);
        wr(12'h054, 32'h0);
        #1 chk("R6 clear dip", int'(irq), 0);
        rd(12'h104, v); chk("R6 reasserts", (v >> 2) & 1, 1);
        set_pin(2, 1'b0); idle(6);
        rd(12'h104, v); chk("R6 level gone", (v >> 2) & 1, 0);

        // R7: single edge rising then falling
        wr(12'h0A0, 32'h59);
        set_pin(5, 1'b1); idle(6);
        rd(12'h104, v); chk("R7 rising set", (v >> 5) & 1, 1);
        set_pin(5, 1'b0); idle(6);
        rd(12'h104, v); chk("R7 latched", (v >> 5) & 1, 1);
        wr(12'h0B4, 32'h0);
        rd(12'h104, v); chk("R7 cleared", (v >> 5) & 1, 0);
        wr(12'h0A0, 32'h49);
        set_pin(5, 1'b1); idle(6);
        rd(12'h104, v); chk("R7 rise ignored", (v >> 5) & 1, 0);
        set_pin(5, 1'b0); idle(6);
        rd(12'h104, v); chk("R7 falling set", (v >> 5) & 1, 1);
        wr(12'h0B4, 32'h0);

        // R8: double edge ignores polarity
        wr(12'h0C0, 32'h4D);
        set_pin(6, 1'b1); idle(6);
        rd(12'h104, v); chk("R8 rise", (v >> 6) & 1, 1);
        wr(12'h0D4, 32'h0);
        rd(12'h104, v); chk("R8 cleared", (v >> 6) & 1, 0);
        set_pin(6, 1'b0); idle(6);
        rd(12'h104, v); chk("R8 fall", (v >> 6) & 1, 1);

        // R10: masking hides the flag from irq without clearing it
        #1 chk("R10 irq on", int'(irq), 1);
        wr(12'h0C0, 32'h0D);
        #1 chk("R10 irq masked", int'(irq), 0);
        rd(12'h104, v); chk("R10 flag kept", (v >> 6) & 1, 1);

        // R9: trigger none and disabled pin raise nothing
        wr(12'h0E0, 32'h41);
        set_pin(7, 1'b1); idle(6);
        set_pin(7, 1'b0); idle(6);
        rd(12'h104, v); chk("R9 none silent", (v >> 7) & 1, 0);
        wr(12'h060, 32'h48);
        set_pin(3, 1'b1); idle(6);
        set_pin(3, 1'b0); idle(6);
        rd(12'h104, v); chk("R9 disabled silent", (v >> 3) & 1, 0);

        idle(3);
        cmp_on = 0;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule